// File: doc/BRIEF.md
# Serial Port Status Register with Read-Armed Clearing

This block is the 8-bit status register of a UART-style serial port. Five event flags live in the upper bits: transmit buffer empty, receive buffer full, overrun, framing error and parity error. The serial datapath sets these flags with single-cycle pulses. Software can only clear them, and only in a fixed order: it must first read the flag as 1, then write a 0 to it. A write of 0 that is not preceded by such a read does nothing. Below the flags are a read-only transmit-end bit, a read-only received multiprocessor bit, and a multiprocessor transmit bit that software can read and write freely.

The transmit-empty flag has more than one hardware source. It is forced to 1 while the transmitter is disabled and each time the transmit buffer is handed to the shifter. A store into the transmit buffer from the DMA path clears it directly, with no prior read.

The CPU port has one-cycle read and write strobes, an 8-bit write bus, and a read bus that shows the current register value combinationally. A power-on reset or a standby request loads the register with 0x84.

Top module: `sio_status_reg`

## Requirements
- R1: The read bus shows bit 7 transmit-empty, bit 6 receive-full, bit 5 overrun, bit 4 framing error, bit 3 parity error, bit 2 transmit-end, bit 1 received multiprocessor bit, and bit 0 multiprocessor transmit bit.
- R2: In the cycle after `rst` or `stby_i` is high, the register reads 0x84, and every flag is disarmed.
- R3: A CPU write never sets a flag in bits 7..3. Writing 1 to a flag bit leaves that flag unchanged.
- R4: A CPU write with 0 in a flag bit clears that flag only if a CPU read returned the flag as 1 after the flag was last set. Otherwise the write leaves the flag at 1.
- R5: Bits 2 and 1 show `tx_end_i` and `rx_mpb_i` as registered one cycle earlier, and CPU writes do not affect them. Bit 0 takes `cpu_wdata_i[0]` on every CPU write.
- R6: Transmit-empty becomes 1 in the cycle after `tx_en_i` is 0 or `tdr_xfer_i` is pulsed.
- R7: A `dma_tdr_wr_i` pulse clears transmit-empty in the next cycle with no prior read, unless a set source is active in the same cycle.
- R8: When a hardware set and a clear hit the same flag in the same cycle, the flag ends at 1 and is disarmed.
- R9: A hardware set that arrives while a flag is already 1 disarms it, so a new read is needed before a clearing write.
- R10: A read and a write of 0 in the same cycle do not clear a flag that was unarmed before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| stby_i | input | 1 | Standby entry; reinitialises the register like reset |
| cpu_rd_i | input | 1 | One-cycle CPU read strobe |
| cpu_wr_i | input | 1 | One-cycle CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Current register value |
| tx_en_i | input | 1 | Transmitter enable; 0 holds transmit-empty at 1 |
| tdr_xfer_i | input | 1 | Pulse: transmit buffer moved to the shifter |
| dma_tdr_wr_i | input | 1 | Pulse: DMA store into the transmit buffer |
| rx_full_set_i | input | 1 | Pulse: a received byte is ready |
| ovr_set_i | input | 1 | Pulse: overrun detected |
| frm_set_i | input | 1 | Pulse: framing error detected |
| par_set_i | input | 1 | Pulse: parity error detected |
| tx_end_i | input | 1 | Transmit-end level from the datapath |
| rx_mpb_i | input | 1 | Received multiprocessor bit from the datapath |

## Verification
The bench targets four orderings, each with the failure it would expose:

- **Write 0 with no prior read.** A design that arms on the write itself would clear the flag and lose an event.
- **Read and clearing write in the same cycle.** A design that arms from the current read would let software clear an event it never observed.
- **Hardware set colliding with a clear.** A design that lets the clear win would drop an event. A design that keeps the arm bit would let a stale read clear a fresh event.
- **The transmit-empty sources in sequence:** transmitter disable, buffer handover, and the DMA store. A design that gives the DMA clear priority over the disable would report a full buffer while the transmitter is off.

Random traffic is then checked against a bench model on every cycle.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;

    localparam int REG_W     = 8;
    localparam int NUM_FLAGS = 5;
    localparam int FLAG_LSB  = 3;
    localparam int TEND_BIT  = 2;
    localparam int MPB_BIT   = 1;
    localparam int MPBT_BIT  = 0;

    localparam logic [REG_W-1:0] INIT_IMAGE = 8'h84;

    // Flag index n maps to register bit FLAG_LSB + n
    typedef enum logic [2:0] {
        FL_PER  = 3'd0,
        FL_FER  = 3'd1,
        FL_ORER = 3'd2,
        FL_RDRF = 3'd3,
        FL_TDRE = 3'd4
    } flag_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [REG_W-1:0] wdata;
    } cpu_req_t;

    typedef struct packed {
        logic set;
        logic hw_clr;
    } flag_ev_t;

    typedef struct packed {
        logic tend;
        logic mpb;
        logic mpbt;
    } ctrl_bits_t;

    function automatic logic [REG_W-1:0] pack_image(
        input logic [NUM_FLAGS-1:0] flags,
        input ctrl_bits_t           cb
    );
        logic [REG_W-1:0] img;
        img                        = '0;
        img[FLAG_LSB +: NUM_FLAGS] = flags;
        img[TEND_BIT]              = cb.tend;
        img[MPB_BIT]               = cb.mpb;
        img[MPBT_BIT]              = cb.mpbt;
        return img;
    endfunction

endpackage

// File: rtl/sio_flag_cell.sv
module sio_flag_cell #(
    parameter logic INIT = 1'b0
) (
    input  logic                   clk,
    input  logic                   init_i,
    input  sio_stat_pkg::cpu_req_t req_i,
    input  logic                   wbit_i,
    input  sio_stat_pkg::flag_ev_t ev_i,
    output logic                   flag_o
);
    logic flag_q;
    logic armed_q;
    logic sw_clr;

    // A clearing write uses the arm state from before this cycle
    assign sw_clr = req_i.wr && !wbit_i && armed_q;

    always_ff @(posedge clk) begin
        if (init_i) begin
            flag_q  <= INIT;
            armed_q <= 1'b0;
        end else if (ev_i.set) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (sw_clr || ev_i.hw_clr) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (req_i.rd && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/sio_ctrl_bits.sv
module sio_ctrl_bits
    import sio_stat_pkg::*;
(
    input  logic       clk,
    input  logic       init_i,
    input  cpu_req_t   req_i,
    input  logic       tx_end_i,
    input  logic       rx_mpb_i,
    output ctrl_bits_t cb_o
);
    ctrl_bits_t cb_q;

    always_ff @(posedge clk) begin
        if (init_i) begin
            cb_q.tend <= INIT_IMAGE[TEND_BIT];
            cb_q.mpb  <= INIT_IMAGE[MPB_BIT];
            cb_q.mpbt <= INIT_IMAGE[MPBT_BIT];
        end else begin
            cb_q.tend <= tx_end_i;
            cb_q.mpb  <= rx_mpb_i;
            if (req_i.wr)
                cb_q.mpbt <= req_i.wdata[MPBT_BIT];
        end
    end

    assign cb_o = cb_q;
endmodule

// File: rtl/sio_status_reg.sv
module sio_status_reg
    import sio_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             stby_i,
    input  logic             cpu_rd_i,
    input  logic             cpu_wr_i,
    input  logic [REG_W-1:0] cpu_wdata_i,
    output logic [REG_W-1:0] cpu_rdata_o,
    input  logic             tx_en_i,
    input  logic             tdr_xfer_i,
    input  logic             dma_tdr_wr_i,
    input  logic             rx_full_set_i,
    input  logic             ovr_set_i,
    input  logic             frm_set_i,
    input  logic             par_set_i,
    input  logic             tx_end_i,
    input  logic             rx_mpb_i
);
    logic                 init;
    cpu_req_t             req;
    flag_ev_t             ev [NUM_FLAGS];
    logic [NUM_FLAGS-1:0] flags;
    ctrl_bits_t           cb;

    assign init      = rst || stby_i;
    assign req.rd    = cpu_rd_i;
    assign req.wr    = cpu_wr_i;
    assign req.wdata = cpu_wdata_i;

    always_comb begin
        for (int n = 0; n < NUM_FLAGS; n++) begin
            ev[n].set    = 1'b0;
            ev[n].hw_clr = 1'b0;
        end
        ev[FL_TDRE].set    = !tx_en_i || tdr_xfer_i;
        ev[FL_TDRE].hw_clr = dma_tdr_wr_i;
        ev[FL_RDRF].set    = rx_full_set_i;
        ev[FL_ORER].set    = ovr_set_i;
        ev[FL_FER].set     = frm_set_i;
        ev[FL_PER].set     = par_set_i;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sio_flag_cell #(
            .INIT (INIT_IMAGE[FLAG_LSB + g])
        ) i_cell (
            .clk    (clk),
            .init_i (init),
            .req_i  (req),
            .wbit_i (cpu_wdata_i[FLAG_LSB + g]),
            .ev_i   (ev[g]),
            .flag_o (flags[g])
        );
    end

    sio_ctrl_bits i_ctrl (
        .clk      (clk),
        .init_i   (init),
        .req_i    (req),
        .tx_end_i (tx_end_i),
        .rx_mpb_i (rx_mpb_i),
        .cb_o     (cb)
    );

    assign cpu_rdata_o = pack_image(flags, cb);
endmodule

// File: rtl/sio_status_chk.sv
module sio_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       stby_i,
    input logic       cpu_rd_i,
    input logic       cpu_wr_i,
    input logic [7:0] cpu_wdata_i,
    input logic [7:0] cpu_rdata_o,
    input logic       tx_en_i,
    input logic       tdr_xfer_i,
    input logic       dma_tdr_wr_i,
    input logic       rx_full_set_i,
    input logic       ovr_set_i,
    input logic       frm_set_i,
    input logic       par_set_i,
    input logic       tx_end_i,
    input logic       rx_mpb_i
);
    logic [4:0] setv;
    assign setv = {!tx_en_i || tdr_xfer_i, rx_full_set_i, ovr_set_i, frm_set_i, par_set_i};

    AST_INIT_IMAGE: assert property (@(posedge clk)
        (rst || stby_i) |=> cpu_rdata_o == 8'h84); // R2

    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
        (!stby_i) |=> ((cpu_rdata_o[7:3] & ~$past(cpu_rdata_o[7:3]) & ~$past(setv)) == 5'd0)); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (!stby_i) |=> ((~cpu_rdata_o[7:3] & $past(setv)) == 5'd0)); // R8

    AST_RO_BITS: assert property (@(posedge clk) disable iff (rst)
        (!stby_i) |=> (cpu_rdata_o[2] == $past(tx_end_i) && cpu_rdata_o[1] == $past(rx_mpb_i))); // R5

    AST_MPBT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!stby_i && cpu_wr_i) |=> cpu_rdata_o[0] == $past(cpu_wdata_i[0])); // R5

    AST_TXOFF_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (!tx_en_i) |=> cpu_rdata_o[7]); // R6
endmodule

bind sio_status_reg sio_status_chk i_chk (.*);

// File: tb/test_sio_status_reg.sv
module test_sio_status_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1, stby_i = 1'b0;
    logic       cpu_rd_i = 1'b0, cpu_wr_i = 1'b0;
    logic [7:0] cpu_wdata_i = 8'h00;
    logic [7:0] cpu_rdata_o;
    logic       tx_en_i = 1'b1, tdr_xfer_i = 1'b0, dma_tdr_wr_i = 1'b0;
    logic       rx_full_set_i = 1'b0, ovr_set_i = 1'b0, frm_set_i = 1'b0, par_set_i = 1'b0;
    logic       tx_end_i = 1'b0, rx_mpb_i = 1'b0;

    int n_chk = 0, n_bad = 0;
    logic       done = 1'b0;

    // bench model: m_flag[4]=bit7 ... m_flag[0]=bit3
    logic [4:0] m_flag = 5'b10000, m_arm = 5'b0;
    logic       m_tend = 1'b1, m_mpb = 1'b0, m_mpbt = 1'b0;

    always #10 clk = ~clk;

    sio_status_reg i_sio_status_reg (.*);

    function automatic logic [7:0] image();
        return {m_flag, m_tend, m_mpb, m_mpbt};
    endfunction

    task automatic compare(input string tag, input logic [7:0] exp);
        n_chk++;
        if (cpu_rdata_o !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, cpu_rdata_o, exp);
        end
    endtask

    // model next state per requirements, advance one clock, check at negedge
    task automatic tick(input string tag);
        logic [4:0] sv, nf, na;
        sv = {!tx_en_i || tdr_xfer_i, rx_full_set_i, ovr_set_i, frm_set_i, par_set_i};
        nf = m_flag; na = m_arm;
        if (rst || stby_i) begin
            nf = 5'b10000; na = 5'b0;
        end else begin
            for (int i = 0; i < 5; i++) begin
                if (sv[i]) begin nf[i] = 1'b1; na[i] = 1'b0; end
                else if ((cpu_wr_i && !cpu_wdata_i[3+i] && m_arm[i]) || (i == 4 && dma_tdr_wr_i)) begin
                    nf[i] = 1'b0; na[i] = 1'b0;
                end else if (cpu_rd_i && m_flag[i]) na[i] = 1'b1;
            end
        end
        @(posedge clk);
        m_flag = nf; m_arm = na;
        if (rst || stby_i) begin
            m_tend = 1'b1; m_mpb = 1'b0; m_mpbt = 1'b0;
        end else begin
            m_tend = tx_end_i; m_mpb = rx_mpb_i;
            if (cpu_wr_i) m_mpbt = cpu_wdata_i[0];
        end
        @(negedge clk);
        compare(tag, image());
        cpu_rd_i = 0; cpu_wr_i = 0; tdr_xfer_i = 0; dma_tdr_wr_i = 0;
        rx_full_set_i = 0; ovr_set_i = 0; frm_set_i = 0; par_set_i = 0;
        rst = 0; stby_i = 0;
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        @(negedge clk);
        rst = 1; tick("R2 reset");
        compare("R2 reset image", 8'h84);
        compare("R1 layout tdre bit7 tend bit2", 8'h84);

        // R4: write 0 without read leaves flag
        rx_full_set_i = 1; tick("R1 rdrf set");
        compare("R1 rdrf on bit6", 8'hC0);
        cpu_wr_i = 1; cpu_wdata_i = 8'h00; tick("R4 unarmed write");
        compare("R4 unarmed write keeps rdrf", 8'hC0);
        // R10: read and write same cycle
        cpu_rd_i = 1; cpu_wr_i = 1; cpu_wdata_i = 8'h00; tick("R10 same cycle");
        compare("R10 same-cycle rd/wr keeps", 8'hC0);
        // now armed from that read; R3 write 1s
        cpu_wr_i = 1; cpu_wdata_i = 8'hFE; tick("R3 write ones");
        compare("R3 writing 1 no change", 8'hC0);
        cpu_wr_i = 1; cpu_wdata_i = 8'h80; tick("R4 armed clear");
        compare("R4 armed clear rdrf", 8'h80);

        // R9: re-set disarms
        ovr_set_i = 1; tick("R9 set");
        cpu_rd_i = 1; tick("R9 read");
        ovr_set_i = 1; tick("R9 reset again");
        cpu_wr_i = 1; cpu_wdata_i = 8'h80; tick("R9 write after reset");
        compare("R9 stale arm ignored", 8'hA0);
        cpu_rd_i = 1; tick("R9 reread");
        cpu_wr_i = 1; cpu_wdata_i = 8'h80; tick("R9 clear");
        compare("R9 cleared after reread", 8'h80);

        // R8: collision
        frm_set_i = 1; tick("R8 set");
        cpu_rd_i = 1; tick("R8 arm");
        frm_set_i = 1; cpu_wr_i = 1; cpu_wdata_i = 8'h80; tick("R8 collide");
        compare("R8 set wins", 8'h90);
        cpu_wr_i = 1; cpu_wdata_i = 8'h80; tick("R8 disarmed");
        compare("R8 disarmed after collision", 8'h90);

        // R7 / R6 transmit-empty sources
        dma_tdr_wr_i = 1; tick("R7 dma clear");
        compare("R7 dma clears tdre", 8'h10);
        tdr_xfer_i = 1; tick("R6 xfer set");
        compare("R6 xfer sets tdre", 8'h90);
        dma_tdr_wr_i = 1; tx_en_i = 0; tick("R6 disabled");
        compare("R6 tx off beats dma", 8'h90);
        tx_en_i = 1;
        par_set_i = 1; tick("R1 per");
        compare("R1 per on bit3", 8'h98);

        // R5 read-only bits and mpbt
        tx_end_i = 1; rx_mpb_i = 1; cpu_wr_i = 1; cpu_wdata_i = 8'h01; tick("R5 ro");
        compare("R5 tend mpb mpbt", 8'h9F);
        tx_end_i = 0; rx_mpb_i = 0; cpu_wr_i = 1; cpu_wdata_i = 8'h06; tick("R5 ro ignore");
        compare("R5 writes to bits2/1 ignored", 8'h98);

        // R2 standby
        stby_i = 1; tick("R2 standby");
        compare("R2 standby image", 8'h84);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            cpu_rd_i      = ($urandom % 2) == 0;
            cpu_wr_i      = ($urandom % 4) == 0;
            cpu_wdata_i   = 8'($urandom);
            tx_en_i       = ($urandom % 8) != 0;
            tdr_xfer_i    = ($urandom % 8) == 0;
            dma_tdr_wr_i  = ($urandom % 8) == 0;
            rx_full_set_i = ($urandom % 8) == 0;
            ovr_set_i     = ($urandom % 16) == 0;
            frm_set_i     = ($urandom % 16) == 0;
            par_set_i     = ($urandom % 16) == 0;
            tx_end_i      = 1'($urandom);
            rx_mpb_i      = 1'($urandom);
            stby_i        = ($urandom % 128) == 0;
            rst           = ($urandom % 256) == 0;
            tick("R4 R8 R9 random");
        end
        tx_en_i = 1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule